// File: doc/BRIEF.md
# SPI Command/Response Slave with Ready Interrupt

This block is a serial peripheral slave that handles a host exchange in two separate chip-select windows. In the first window the host shifts a command packet into the slave on MOSI. When the window closes, the slave runs a fixed-latency processing step. It then pulls an active-low ready interrupt low. In the second window the host clocks the response out on MISO. The slave releases the interrupt as soon as that window opens.

The serial pins are sampled by the block's own system clock through synchronizers, so the SPI clock must be much slower than the system clock. The processing step is a deterministic stub. The response is the number of whole command bytes received, then those bytes in reverse order, then 0xFF filler. No valid/ready stream is exposed at the edge, because the packet never leaves the block. The internal byte strobe from the shifter to the packet store carries no back-pressure: the store takes a byte every time, or drops it once it is full.

Top module: `spi_cr_slave`

## Requirements
- R1: After reset, irq_n is 1 and miso_oe is 0.
- R2: While ssel_n is low in the command phase, MOSI is sampled on each SCK rising edge, most significant bit first. Each complete 8-bit group is stored. The store keeps at most MAX_BYTES bytes; further bytes are dropped and the count stays at MAX_BYTES.
- R3: If ssel_n rises partway through a byte, that partial byte is discarded and is not counted.
- R4: irq_n stays 1 while processing. It falls to 0 PROC_CYCLES system clocks after the synchronized rising edge of ssel_n that closes the command window, and it falls at no other time.
- R5: irq_n stays 0 until ssel_n falls. It returns to 1 within 4 system clocks of that fall, before the first SCK edge of the response window.
- R6: In the response window, MISO carries the following bytes, most significant bit first, with each bit changed on the SCK falling edge. The first byte is the stored count. Next come the stored bytes from last received to first. Every byte after those is 0xFF. The first bit is valid before the first SCK rise.
- R7: MOSI data during the response window has no effect on the response bytes.
- R8: miso_oe is 0 whenever ssel_n has been high for at least 3 system clocks, and 1 while it is low.
- R9: During the command window, MISO shifts out only ones, so every byte the host reads there is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run many times faster than SCK |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | SPI clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| ssel_n | input | 1 | Active-low chip select from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the MISO pad driver; 0 means high impedance |
| irq_n | output | 1 | Active-low response-ready interrupt |

## Verification
The assertions assume that every SCK and ssel_n edge is held for longer than the synchronizer depth plus one system clock. They also assume that SCK is low whenever ssel_n changes, and that the host opens the response window only after irq_n has fallen. The stimulus stays within these limits. It holds each SCK half period for 8 system clocks and waits 10 clocks between an ssel_n edge and the first SCK edge. It always waits for the interrupt before reading. The stimulus sweeps command lengths from empty to beyond the store size and adds one window that ends on a partial byte.

// File: rtl/spi_cr_pkg.sv
package spi_cr_pkg;
  typedef enum logic [2:0] {
    PH_CMD_WAIT,
    PH_CMD_RX,
    PH_PROC,
    PH_READY,
    PH_RSP_TX
  } phase_t;
endpackage

// File: rtl/spi_cr_sync.sv
module spi_cr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic ssel_n,
  output logic mosi_q,
  output logic ssel_q,
  output logic sck_rise,
  output logic sck_fall,
  output logic ssel_fall,
  output logic ssel_rise
);
  logic [STAGES-1:0] sck_p, mosi_p, ssel_p;
  logic sck_d, ssel_d;
  logic sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_p  <= '0;
      mosi_p <= '0;
      ssel_p <= '1;
      sck_d  <= 1'b0;
      ssel_d <= 1'b1;
    end else begin
      sck_p  <= {sck_p[STAGES-2:0], sck};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
      ssel_p <= {ssel_p[STAGES-2:0], ssel_n};
      sck_d  <= sck_p[STAGES-1];
      ssel_d <= ssel_p[STAGES-1];
    end
  end

  assign sck_q     = sck_p[STAGES-1];
  assign mosi_q    = mosi_p[STAGES-1];
  assign ssel_q    = ssel_p[STAGES-1];
  assign sck_rise  = sck_q & ~sck_d;
  assign sck_fall  = ~sck_q & sck_d;
  assign ssel_fall = ~ssel_q & ssel_d;
  assign ssel_rise = ssel_q & ~ssel_d;
endmodule

// File: rtl/spi_cr_shift.sv
module spi_cr_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         start,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         mosi_bit,
  input  logic [W-1:0] tx_byte,
  output logic [W-1:0] rx_byte,
  output logic         rx_valid,
  output logic         tx_load,
  output logic         miso_bit
);
  localparam int BW = $clog2(W);

  logic [BW-1:0] rx_bits, tx_bits;
  logic [W-1:0]  rx_sh, tx_sh;

  assign tx_load = start | (active & sck_fall & (tx_bits == BW'(W-1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_bits  <= '0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (start) begin
        rx_bits <= '0;
      end else if (active && sck_rise) begin
        rx_sh <= {rx_sh[W-2:0], mosi_bit};
        if (rx_bits == BW'(W-1)) begin
          rx_bits  <= '0;
          rx_valid <= 1'b1;
        end else begin
          rx_bits <= rx_bits + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_bits <= '0;
      tx_sh   <= '1;
    end else if (tx_load) begin
      tx_sh   <= tx_byte;
      tx_bits <= '0;
    end else if (active && sck_fall) begin
      tx_sh   <= {tx_sh[W-2:0], 1'b1};
      tx_bits <= tx_bits + 1'b1;
    end
  end

  assign rx_byte  = rx_sh;
  assign miso_bit = tx_sh[W-1];

  // R6: a loaded byte appears whole in the shifter on the next cycle
  p_load_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (tx_sh == $past(tx_byte)));
  // R2: a completed byte resets the bit position for the next byte
  p_byte_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_bits == '0));
endmodule

// File: rtl/spi_cr_store.sv
module spi_cr_store #(
  parameter int MAX_BYTES = 32,
  parameter int W         = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clear,
  input  logic                              wr_en,
  input  logic [W-1:0]                      wr_data,
  input  logic [$clog2(MAX_BYTES+2)-1:0]    rd_idx,
  output logic [$clog2(MAX_BYTES+1)-1:0]    count,
  output logic [W-1:0]                      rd_data
);
  localparam int CW = $clog2(MAX_BYTES + 1);
  localparam int IW = $clog2(MAX_BYTES + 2);
  localparam int AW = $clog2(MAX_BYTES);

  logic [W-1:0]  mem [MAX_BYTES];
  logic [IW-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (wr_en && (count < CW'(MAX_BYTES))) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!clear && wr_en && (count < CW'(MAX_BYTES))) begin
      mem[count[AW-1:0]] <= wr_data;
    end
  end

  assign pos = IW'(count) - rd_idx;

  always_comb begin
    if (rd_idx == '0) begin
      rd_data = W'(count);
    end else if (rd_idx <= IW'(count)) begin
      rd_data = mem[pos[AW-1:0]];
    end else begin
      rd_data = '1;
    end
  end

  // R2: a full store keeps its count when more bytes arrive
  p_count_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && wr_en && (count == CW'(MAX_BYTES))) |=> (count == CW'(MAX_BYTES)));
endmodule

// File: rtl/spi_cr_slave.sv
module spi_cr_slave
  import spi_cr_pkg::*;
#(
  parameter int MAX_BYTES   = 32,
  parameter int PROC_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic ssel_n,
  output logic miso,
  output logic miso_oe,
  output logic irq_n
);
  localparam int W  = 8;
  localparam int CW = $clog2(MAX_BYTES + 1);
  localparam int IW = $clog2(MAX_BYTES + 2);
  localparam int PW = $clog2(PROC_CYCLES + 1);

  phase_t        phase;
  logic [PW-1:0] proc_cnt;
  logic [IW-1:0] rsp_idx;
  logic          mosi_q, ssel_q, sck_rise, sck_fall, ssel_fall, ssel_rise;
  logic [W-1:0]  rx_byte, tx_byte, rd_data;
  logic          rx_valid, tx_load;
  logic [CW-1:0] count;

  spi_cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ssel_n(ssel_n),
    .mosi_q(mosi_q), .ssel_q(ssel_q), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .ssel_fall(ssel_fall), .ssel_rise(ssel_rise)
  );

  spi_cr_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .active(!ssel_q), .start(ssel_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_bit(mosi_q),
    .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .tx_load(tx_load), .miso_bit(miso)
  );

  spi_cr_store #(.MAX_BYTES(MAX_BYTES), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .clear((phase == PH_CMD_WAIT) && ssel_fall),
    .wr_en((phase == PH_CMD_RX) && rx_valid),
    .wr_data(rx_byte), .rd_idx(rsp_idx), .count(count), .rd_data(rd_data)
  );

  assign tx_byte = ((phase == PH_READY) || (phase == PH_RSP_TX)) ? rd_data : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_idx <= '0;
    end else if (ssel_q) begin
      rsp_idx <= '0;
    end else if (tx_load && (rsp_idx != IW'(MAX_BYTES + 1))) begin
      rsp_idx <= rsp_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_CMD_WAIT;
      proc_cnt <= '0;
    end else begin
      unique case (phase)
        PH_CMD_WAIT: if (ssel_fall) phase <= PH_CMD_RX;
        PH_CMD_RX: if (ssel_rise) begin
          phase    <= PH_PROC;
          proc_cnt <= '0;
        end
        PH_PROC: begin
          if (proc_cnt == PW'(PROC_CYCLES - 1)) phase <= PH_READY;
          else proc_cnt <= proc_cnt + 1'b1;
        end
        PH_READY: if (ssel_fall) phase <= PH_RSP_TX;
        PH_RSP_TX: if (ssel_rise) phase <= PH_CMD_WAIT;
        default: phase <= PH_CMD_WAIT;
      endcase
    end
  end

  assign irq_n   = (phase != PH_READY);
  assign miso_oe = !ssel_q;

  // R8: chip select held high at the pin turns the driver off
  p_oe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ssel_n && $past(ssel_n) && $past(ssel_n, 2) && $past(ssel_n, 3)) |-> !miso_oe);
  // R5: the response window opening releases the interrupt next cycle
  p_irq_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_READY) && ssel_fall) |=> irq_n);
  // R4: the interrupt only falls at the end of processing
  p_irq_from_proc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(phase) == PH_PROC));
  // R6: the response index never passes the filler position
  p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_idx == IW'(MAX_BYTES + 1)) |=> (rsp_idx <= IW'(MAX_BYTES + 1)));
endmodule

// File: tb/sim_spi_cr_slave.sv
`timescale 1ns/1ps
module sim_spi_cr_slave;
  localparam int MAXB = 8;
  localparam int PROC = 16;
  localparam int H    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ssel_n = 1'b1;
  logic miso, miso_oe, irq_n;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] cmd [64];

  always #2.5 clk = ~clk;

  spi_cr_slave #(.MAX_BYTES(MAXB), .PROC_CYCLES(PROC), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ssel_n(ssel_n),
    .miso(miso), .miso_oe(miso_oe), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int b = 0; b < nbits; b++) begin
      mosi = tx[7-b];
      wait_clk(H);
      rx[7-b] = miso;
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
  endtask

  // Command window of n whole bytes plus an optional partial byte
  task automatic cmd_window(input int n, input int extra_bits);
    logic [7:0] rx;
    int ff_ok = 1;
    ssel_n = 1'b0;
    wait_clk(10);
    check("R8 oe on in window", miso_oe, 1'b1);
    for (int i = 0; i < n; i++) begin
      xfer(cmd[i], 8, rx);
      if (rx !== 8'hFF) ff_ok = 0;
    end
    if (extra_bits > 0) xfer(8'h5A, extra_bits, rx);
    check("R9 cmd-phase MISO all ones", ff_ok, 1);
    wait_clk(4);
    ssel_n = 1'b1;
    wait_clk(5);
    check("R4 irq held high while processing", irq_n, 1'b1);
    check("R8 oe off after window", miso_oe, 1'b0);
  endtask

  task automatic wait_irq();
    int t = 0;
    while (irq_n !== 1'b0 && t < 200) begin
      wait_clk(1);
      t++;
    end
    check("R4 irq falls after processing", irq_n, 1'b0);
    wait_clk(20);
    check("R5 irq held low until window", irq_n, 1'b0);
  endtask

  task automatic rsp_window(input int stored, input logic [7:0] junk);
    logic [7:0] rx, exp;
    ssel_n = 1'b0;
    wait_clk(4);
    check("R5 irq released at window start", irq_n, 1'b1);
    wait_clk(6);
    for (int k = 0; k < stored + 3; k++) begin
      xfer(junk ^ 8'(k * 17), 8, rx);
      if (k == 0) exp = 8'(stored);
      else if (k <= stored) exp = cmd[stored - k];
      else exp = 8'hFF;
      if (k == 0) check("R6 count byte", rx, exp);
      else if (k <= stored) check("R6/R7 reversed byte", rx, exp);
      else check("R6 filler 0xFF", rx, exp);
    end
    wait_clk(4);
    ssel_n = 1'b1;
    wait_clk(5);
    check("R8 oe off after response", miso_oe, 1'b0);
    check("R5 irq stays high after response", irq_n, 1'b1);
  endtask

  initial begin
    wait_clk(5);
    check("R1 irq_n after reset", irq_n, 1'b1);
    check("R1 miso_oe after reset", miso_oe, 1'b0);
    rst_n = 1'b1;
    wait_clk(5);
    check("R1 irq_n idle", irq_n, 1'b1);

    // R2/R6/R7 sweep: lengths from empty to beyond store size
    for (int n = 0; n <= MAXB + 3; n++) begin
      for (int i = 0; i < n; i++) cmd[i] = 8'(n * 29 + i * 73 + 1);
      cmd_window(n, 0);
      wait_irq();
      rsp_window((n > MAXB) ? MAXB : n, 8'(n * 91 + 3));
    end

    // R3: partial byte at the end of the window is discarded
    for (int i = 0; i < 3; i++) cmd[i] = 8'(i * 45 + 200);
    cmd_window(3, 5);
    wait_irq();
    rsp_window(3, 8'h00);

    // R7: all-ones MOSI in the response phase
    for (int i = 0; i < 4; i++) cmd[i] = 8'(i + 1);
    cmd_window(4, 0);
    wait_irq();
    rsp_window(4, 8'hFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule